// File: doc/BRIEF.md
# SPI Command Front End for a 32-Pin ADC/GPIO Hub

This block is the serial slave front end of a mixed-signal monitoring hub with 32 pins, each usable as an analog input or a general-purpose I/O. A host sends 16-bit frames in SPI mode 0, most significant bit first. The first byte of each frame is a command and the second byte is a payload. The block moves all serial pins into the system clock domain and counts the SCLK edges of each frame. When chip select rises it decodes the command. It then writes a byte to the pin-configuration bank, reads a byte from that bank, or asks an external converter for a 12-bit sample.

Results are returned one frame later. When a read command is decoded, the block fetches the value before the host starts its next frame. It then shifts the value out on MISO during that frame. A register value comes back in the low byte. A sample comes back in the low 12 bits, with a flag bit set when the addressed pin is currently assigned to GPIO. A frame that decodes to anything other than a read leaves an all-zero word for the next frame.

Top module: `spi_adc_gpio_frontend`

## Requirements
- R1: A frame is MSB first in SPI mode 0. MOSI is taken on SCLK rising edges. MISO shows the response MSB from the time chip select falls, and advances one bit after each SCLK falling edge.
- R2: The command is the first byte of the frame. Bits 7:6 must be zero, otherwise the frame is dropped. Bit 5 selects a register access (1) or a sample (0). Bit 4 chooses a register read (1) or a register write (0). Bits 3:0 give the register address.
- R3: A 16-edge frame whose command has bit 5 = 1 and bit 4 = 0 gives exactly one `reg_wr_en` pulse after chip select rises. The pulse carries `reg_addr` = command bits 3:0 and `reg_wdata` = the second byte.
- R4: A command with bit 5 = 1 and bit 4 = 1 gives one `reg_rd_en` pulse with the address from bits 3:0. `reg_rdata` is taken one cycle after the pulse. The next frame returns it as {8'h00, value}.
- R5: A command with bit 5 = 0 raises `smp_req` with `smp_chan` = command bits 4:0. Both stay steady until `smp_ack`. The next frame returns the sample in bits 11:0, `pin_is_gpio[chan]` in bit 14, and zeros elsewhere.
- R6: A frame that ends with a SCLK edge count other than 16 is dropped. It gives no register write and no request, and the next frame returns zero.
- R7: When the previous frame was not a valid read (for example a write), MISO returns 16'h0000.
- R8: A read result is returned only in the frame that immediately follows the read command. A frame that itself carries a new read still returns the older result.
- R9: During and after reset, MISO, `reg_wr_en`, `reg_rd_en` and `smp_req` are low.
- R10: `reg_wr_en` and `reg_rd_en` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host to block serial data |
| spi_miso | output | 1 | Block to host serial data |
| reg_wr_en | output | 1 | Configuration bank write strobe |
| reg_rd_en | output | 1 | Configuration bank read strobe |
| reg_addr | output | 4 | Configuration register address |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid one cycle after reg_rd_en |
| smp_req | output | 1 | Sample request, held until acknowledged |
| smp_chan | output | 5 | Requested channel (0-15 A side, 16-31 B side) |
| smp_ack | input | 1 | Sample ready strobe |
| smp_data | input | 12 | Sample value, valid with smp_ack |
| pin_is_gpio | input | 32 | Per-pin marker: pin currently in GPIO use |

## Verification
The assertions assume a host and converter that follow the rules below.
- The host starts no frame while a fetch is still running.
- The host keeps SCLK low whenever chip select is high.
- The converter raises `smp_ack` only while `smp_req` is high.
- The bank answers a read exactly one cycle after the strobe.

The stimulus keeps to these rules. Each SCLK phase lasts six system clocks. Frames are separated by twenty idle clocks. The modelled converter acknowledges three cycles after a request and then stays silent until the next request. A behavioural bench bank answers reads with the one-cycle delay.

// File: rtl/spi_hub_pkg.sv
package spi_hub_pkg;
  // Positions inside the command byte; a host encodes them, so they are fixed.
  localparam int CMD_IO_BIT = 5;
  localparam int CMD_RW_BIT = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_CAP,
    ST_SMP_WAIT
  } ctrl_state_e;
endpackage

// File: rtl/hub_sync.sv
module hub_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hub_frame_rx.sv
module hub_frame_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               csn_s,
  input  logic               mosi_s,
  output logic               sclk_fall,
  output logic               frame_end,
  output logic               frame_ok,
  output logic [FRAME_W-1:0] frame_data
);
  localparam int CNT_W = $clog2(FRAME_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sclk_d, csn_d;
  logic [CNT_W-1:0] bit_cnt;
  logic             sclk_rise, frame_start;

  assign sclk_rise   = sclk_s & ~sclk_d;
  assign sclk_fall   = ~sclk_s & sclk_d;
  assign frame_start = ~csn_s & csn_d;
  assign frame_end   = csn_s & ~csn_d;
  assign frame_ok    = (bit_cnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b0;
      csn_d      <= 1'b1;
      bit_cnt    <= '0;
      frame_data <= '0;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
      if (frame_start) begin
        bit_cnt <= '0;
      end else if (!csn_s && sclk_rise) begin
        frame_data <= {frame_data[FRAME_W-2:0], mosi_s};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hub_tx_shift.sv
module hub_tx_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               csn_s,
  input  logic               sclk_fall,
  input  logic [FRAME_W-1:0] load_word,
  output logic               miso
);
  logic [FRAME_W-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst)            tx_sr <= '0;
    else if (csn_s)     tx_sr <= load_word;
    else if (sclk_fall) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
  end

  assign miso = tx_sr[FRAME_W-1];

  // R1
  miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!csn_s && $past(!csn_s) && !$past(sclk_fall)) |-> $stable(miso));
endmodule

// File: rtl/hub_cmd_ctrl.sv
module hub_cmd_ctrl
  import spi_hub_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADC_W    = 12,
  parameter int CHAN_W   = 5,
  parameter int ADDR_W   = 4,
  parameter int FLAG_BIT = 14,
  parameter int NUM_CHAN = 1 << CHAN_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_end,
  input  logic                frame_ok,
  input  logic [2*DATA_W-1:0] frame_data,
  input  logic [DATA_W-1:0]   reg_rdata,
  input  logic                smp_ack,
  input  logic [ADC_W-1:0]    smp_data,
  input  logic [NUM_CHAN-1:0] pin_is_gpio,
  output logic                reg_wr_en,
  output logic                reg_rd_en,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic [DATA_W-1:0]   reg_wdata,
  output logic                smp_req,
  output logic [CHAN_W-1:0]   smp_chan,
  output logic [2*DATA_W-1:0] resp_word
);
  localparam int FRAME_W = 2 * DATA_W;

  ctrl_state_e        state;
  logic [DATA_W-1:0]  cmd, payload;
  logic               cmd_legal, gpio_flag;
  logic [FRAME_W-1:0] adc_word, reg_word;

  assign cmd       = frame_data[FRAME_W-1 -: DATA_W];
  assign payload   = frame_data[DATA_W-1:0];
  assign cmd_legal = (cmd[DATA_W-1:CMD_IO_BIT+1] == '0);

  always_comb begin
    adc_word                = '0;
    adc_word[ADC_W-1:0]     = smp_data;
    adc_word[FLAG_BIT]      = gpio_flag;
    reg_word                = '0;
    reg_word[DATA_W-1:0]    = reg_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      smp_req   <= 1'b0;
      smp_chan  <= '0;
      gpio_flag <= 1'b0;
      resp_word <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (frame_end) begin
            resp_word <= '0;
            if (frame_ok && cmd_legal) begin
              if (cmd[CMD_IO_BIT]) begin
                reg_addr <= cmd[ADDR_W-1:0];
                if (cmd[CMD_RW_BIT]) begin
                  reg_rd_en <= 1'b1;
                  state     <= ST_RD_WAIT;
                end else begin
                  reg_wr_en <= 1'b1;
                  reg_wdata <= payload;
                end
              end else begin
                smp_req   <= 1'b1;
                smp_chan  <= cmd[CHAN_W-1:0];
                gpio_flag <= pin_is_gpio[cmd[CHAN_W-1:0]];
                state     <= ST_SMP_WAIT;
              end
            end
          end
        end
        ST_RD_WAIT: state <= ST_RD_CAP;
        ST_RD_CAP: begin
          resp_word <= reg_word;
          state     <= ST_IDLE;
        end
        ST_SMP_WAIT: begin
          if (smp_ack) begin
            smp_req   <= 1'b0;
            resp_word <= adc_word;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);
  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> !reg_rd_en);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && reg_rd_en));
  // R3 R6
  wr_full_frame_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> $past(frame_end && frame_ok));
  // R5
  smp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_req && !smp_ack) |=> (smp_req && $stable(smp_chan)));
  // R5
  smp_release_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_req && smp_ack) |=> !smp_req);
endmodule

// File: rtl/spi_adc_gpio_frontend.sv
module spi_adc_gpio_frontend #(
  parameter int DATA_W      = 8,
  parameter int ADC_W       = 12,
  parameter int CHAN_W      = 5,
  parameter int ADDR_W      = 4,
  parameter int FLAG_BIT    = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   spi_sclk,
  input  logic                   spi_csn,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  output logic                   reg_wr_en,
  output logic                   reg_rd_en,
  output logic [ADDR_W-1:0]      reg_addr,
  output logic [DATA_W-1:0]      reg_wdata,
  input  logic [DATA_W-1:0]      reg_rdata,
  output logic                   smp_req,
  output logic [CHAN_W-1:0]      smp_chan,
  input  logic                   smp_ack,
  input  logic [ADC_W-1:0]       smp_data,
  input  logic [(1<<CHAN_W)-1:0] pin_is_gpio
);
  localparam int FRAME_W  = 2 * DATA_W;
  localparam int NUM_CHAN = 1 << CHAN_W;

  logic               sclk_s, csn_s, mosi_s;
  logic               sclk_fall, frame_end, frame_ok;
  logic [FRAME_W-1:0] frame_data, resp_word;

  hub_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst(rst), .d(spi_csn), .q(csn_s)
  );

  hub_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_dat (
    .clk(clk), .rst(rst), .d({spi_sclk, spi_mosi}), .q({sclk_s, mosi_s})
  );

  hub_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .csn_s(csn_s), .mosi_s(mosi_s),
    .sclk_fall(sclk_fall), .frame_end(frame_end), .frame_ok(frame_ok),
    .frame_data(frame_data)
  );

  hub_cmd_ctrl #(
    .DATA_W(DATA_W), .ADC_W(ADC_W), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W),
    .FLAG_BIT(FLAG_BIT), .NUM_CHAN(NUM_CHAN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .frame_end(frame_end), .frame_ok(frame_ok),
    .frame_data(frame_data), .reg_rdata(reg_rdata), .smp_ack(smp_ack),
    .smp_data(smp_data), .pin_is_gpio(pin_is_gpio),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .smp_req(smp_req), .smp_chan(smp_chan),
    .resp_word(resp_word)
  );

  hub_tx_shift #(.FRAME_W(FRAME_W)) u_tx (
    .clk(clk), .rst(rst), .csn_s(csn_s), .sclk_fall(sclk_fall),
    .load_word(resp_word), .miso(spi_miso)
  );
endmodule

// File: tb/tb_spi_adc_gpio_frontend.sv
module tb_spi_adc_gpio_frontend;
  localparam int H   = 6;
  localparam int GAP = 20;
  localparam logic [31:0] GPIO_MASK = 32'h8002_0F00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso;
  logic        reg_wr_en, reg_rd_en;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        smp_req, smp_ack;
  logic [4:0]  smp_chan;
  logic [11:0] smp_data;
  logic [31:0] pin_is_gpio = GPIO_MASK;

  int compared = 0, mismatched = 0;
  int q_wr[$], q_rd[$], q_smp[$];
  logic [15:0] exp_resp = 16'h0;
  logic [7:0]  bank [16];
  int          ack_cnt;
  logic        prev_req;

  always #10 clk = ~clk;

  spi_adc_gpio_frontend dut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .smp_req(smp_req), .smp_chan(smp_chan),
    .smp_ack(smp_ack), .smp_data(smp_data), .pin_is_gpio(pin_is_gpio)
  );

  function automatic logic [11:0] adc_val(input int ch);
    return 12'((ch * 291 + 7) & 12'hFFF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural configuration bank: one-cycle read latency.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) bank[i] <= 8'(8'h40 + i);
      reg_rdata <= 8'h00;
    end else begin
      if (reg_wr_en) bank[reg_addr] <= reg_wdata;
      if (reg_rd_en) reg_rdata <= bank[reg_addr];
    end
  end

  // Behavioural converter: acknowledges three cycles after a request.
  always @(posedge clk) begin
    if (rst) begin
      smp_ack  <= 1'b0;
      smp_data <= 12'h0;
      ack_cnt  <= 0;
    end else if (smp_req && !smp_ack) begin
      if (ack_cnt == 2) begin
        smp_ack  <= 1'b1;
        smp_data <= adc_val(int'(smp_chan));
        ack_cnt  <= 0;
      end else begin
        ack_cnt <= ack_cnt + 1;
      end
    end else begin
      smp_ack <= 1'b0;
    end
  end

  // Event monitor, compared on every clock against the expected queues.
  always @(negedge clk) begin
    if (rst) begin
      prev_req <= 1'b0;
    end else begin
      prev_req <= smp_req;
      if (reg_wr_en) begin
        if (q_wr.size() == 0) check("R3 R6 unexpected write", {reg_addr, reg_wdata}, 32'hFFFF);
        else check("R3 write", {20'h0, reg_addr, reg_wdata}, 32'(q_wr.pop_front()));
      end
      if (reg_rd_en) begin
        if (q_rd.size() == 0) check("R4 R6 unexpected read", {28'h0, reg_addr}, 32'hFFFF);
        else check("R4 read address", {28'h0, reg_addr}, 32'(q_rd.pop_front()));
      end
      if (smp_req && !prev_req) begin
        if (q_smp.size() == 0) check("R5 R6 unexpected request", {27'h0, smp_chan}, 32'hFFFF);
        else check("R5 request channel", {27'h0, smp_chan}, 32'(q_smp.pop_front()));
      end
      if (reg_wr_en && reg_rd_en) check("R10 strobes together", 32'h1, 32'h0);
    end
  end

  function automatic logic [15:0] predict(input logic [15:0] w, input int nbits);
    logic [7:0] c;
    c = w[15:8];
    if (nbits != 16 || c[7:6] != 2'b00) return 16'h0;
    if (c[5]) begin
      if (c[4]) begin
        q_rd.push_back(int'(c[3:0]));
        return {8'h00, bank[c[3:0]]};
      end
      q_wr.push_back(int'({c[3:0], w[7:0]}));
      return 16'h0;
    end
    q_smp.push_back(int'(c[4:0]));
    return {1'b0, GPIO_MASK[c[4:0]], 2'b00, adc_val(int'(c[4:0]))};
  endfunction

  task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] r);
    r = '0;
    @(negedge clk);
    spi_csn = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = w[15-i];
      repeat (H) @(negedge clk);
      r = {r[14:0], spi_miso};
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    spi_csn = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic run(input logic [15:0] w, input int nbits, input string req);
    logic [15:0] r, nxt;
    nxt = predict(w, nbits);
    xfer(w, nbits, r);
    if (nbits == 16) check(req, {16'h0, r}, {16'h0, exp_resp});
    exp_resp = nxt;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    check("R9 miso in reset", {31'h0, spi_miso}, 32'h0);
    check("R9 strobes in reset", {29'h0, reg_wr_en, reg_rd_en, smp_req}, 32'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 outputs after reset", {28'h0, spi_miso, reg_wr_en, reg_rd_en, smp_req}, 32'h0);

    run(16'h23A5, 16, "R1 R7 first frame");         // write reg 3
    run(16'h3300, 16, "R7 after write");            // read reg 3
    run(16'h0000, 16, "R1 R4 register read");       // sample ch 0 issued here
    run(16'h0000, 16, "R5 ch0 analog");             // ch 0 again
    run(16'h1100, 16, "R5 ch0 repeat");             // ch 17 (B side, gpio)
    run(16'h1F00, 16, "R5 R8 ch17 flag");           // ch 31 gpio
    run(16'h0F00, 16, "R5 ch31 flag");              // ch 15 analog
    run(16'h0500, 16, "R5 ch15 no flag");           // ch 5
    run(16'h3300, 16, "R8 ch5 before reg read");    // reg read chained
    run(16'h0000, 16, "R8 chained reg read");       // ch 0
    run(16'h2F5A, 16, "R8 ch0 chained");            // write reg 15
    run(16'h3F00, 16, "R7 after write 15");         // read reg 15
    run(16'h2000, 16, "R3 R4 reg15 readback");      // write reg 0 = 0
    run(16'h8321, 16, "R7 after write 0");          // illegal top bits
    run(16'h3000, 16, "R2 illegal command");        // read reg 0
    run(16'h6A00, 16, "R4 reg0 after write");       // illegal bit 6
    run(16'h2377, 10, "R6 short frame");            // short write
    run(16'h3300, 16, "R2 R6 zero after drop");     // read reg 3, unchanged
    run(16'h0900, 16, "R4 reg3 unchanged");         // ch 9 gpio
    run(16'h0000, 16, "R5 ch9 flag");
    run(16'h0000, 16, "R7 final");

    check("R3 R4 R5 pending events", 32'(q_wr.size() + q_rd.size() + q_smp.size()), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule